// File: doc/BRIEF.md
# Paired-Object Trigger Condition Evaluator

On every bunch-crossing cycle the block receives four candidate objects of one kind. Each candidate has a transverse energy, an eta code, a phi code and an isolation flag. The block raises a pair condition when two different candidates satisfy two independent requirement sets, one candidate for each set. Each set applies an energy threshold, an eta window and a phi window, and it can optionally demand isolation. When the correlation option is on, the matched pair must also lie within a programmed eta separation and a programmed phi separation. Phi separation is measured on the circular phi scale.

Next to the pair condition, a missing-energy value is compared with its own threshold and reported as a second condition bit. Thresholds, windows and limits arrive on configuration inputs that software registers drive, so the logic stays fixed while the physics cuts change. Both results appear with a constant latency of two clock edges. A downstream stage can therefore combine them with other conditions on the same crossing.

Top module: `trig_pair_cond`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by two rising clock edges. Whenever `valid_o` is 0, `pair_o` and `met_o` are 0.
- R2: A candidate meets a set's energy cut when its energy is greater than or equal to that set's threshold. Equality passes.
- R3: A candidate meets a set's eta cut when lo <= eta <= hi, with both bounds inclusive.
- R4: The phi cut is inclusive. When lo <= hi it passes lo <= phi <= hi. When lo > hi the window wraps, and it passes phi >= lo or phi <= hi.
- R5: When a set's isolation-required bit is 1, a candidate whose isolation flag is 0 never meets that set.
- R6: `pair_o` is 1 only if some candidate i meets set 1, some other candidate j != i meets set 2, and the correlation rule holds for (i, j). A single candidate that meets both sets does not produce a pair.
- R7: With correlation enabled, the pair (i, j) also needs |eta_i - eta_j| <= the eta limit and a phi distance <= the phi limit. With correlation disabled, both limits have no effect.
- R8: The phi distance is min(d, PHI_BINS - d), where d = |phi_i - phi_j| and PHI_BINS defaults to 72.
- R9: `met_o` is 1 for a valid crossing when the missing-energy value is greater than or equal to its threshold, with equality passing.
- R10: An active-low reset clears `valid_o`, `pair_o` and `met_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Candidate data valid for this crossing |
| obj_et_i | input | N_OBJ*ET_W | Candidate energies, candidate 0 in the low bits |
| obj_eta_i | input | N_OBJ*ETA_W | Candidate eta codes |
| obj_phi_i | input | N_OBJ*PHI_W | Candidate phi codes, 0..PHI_BINS-1 |
| obj_iso_i | input | N_OBJ | Candidate isolation flags |
| met_i | input | MET_W | Missing-energy value |
| s1_et_thr_i | input | ET_W | Set 1 energy threshold |
| s1_eta_lo_i | input | ETA_W | Set 1 eta lower bound |
| s1_eta_hi_i | input | ETA_W | Set 1 eta upper bound |
| s1_phi_lo_i | input | PHI_W | Set 1 phi lower bound |
| s1_phi_hi_i | input | PHI_W | Set 1 phi upper bound |
| s1_iso_req_i | input | 1 | Set 1 requires isolation |
| s2_et_thr_i | input | ET_W | Set 2 energy threshold |
| s2_eta_lo_i | input | ETA_W | Set 2 eta lower bound |
| s2_eta_hi_i | input | ETA_W | Set 2 eta upper bound |
| s2_phi_lo_i | input | PHI_W | Set 2 phi lower bound |
| s2_phi_hi_i | input | PHI_W | Set 2 phi upper bound |
| s2_iso_req_i | input | 1 | Set 2 requires isolation |
| corr_en_i | input | 1 | Enable pair separation limits |
| deta_max_i | input | ETA_W | Maximum eta separation |
| dphi_max_i | input | PHI_W | Maximum wrapped phi separation |
| met_thr_i | input | MET_W | Missing-energy threshold |
| valid_o | output | 1 | Result valid |
| pair_o | output | 1 | Pair condition |
| met_o | output | 1 | Missing-energy condition |

## Verification
The hardest case to reach is a crossing where one candidate satisfies both sets and another candidate satisfies only one. For such a crossing, the outcome depends on which ordered pair survives the separation test. The stimulus builds crossings of this kind with hand-picked codes. In one, the only usable ordering fails on eta separation. In another, the phi values sit on opposite sides of the wrap point, so the short arc passes and the long arc would fail. Boundary values of each window and threshold are placed exactly on the limit and one step past it.

// File: rtl/trig_pair_pkg.sv
package trig_pair_pkg;
    localparam int DEF_N_OBJ    = 4;
    localparam int DEF_ET_W     = 10;
    localparam int DEF_ETA_W    = 6;
    localparam int DEF_PHI_W    = 7;
    localparam int DEF_PHI_BINS = 72;
    localparam int DEF_MET_W    = 12;
    localparam int N_SETS       = 2;
endpackage

// File: rtl/obj_match.sv
module obj_match #(
    parameter int ET_W  = 10,
    parameter int ETA_W = 6,
    parameter int PHI_W = 7
) (
    input  logic [ET_W-1:0]  et_i,
    input  logic [ETA_W-1:0] eta_i,
    input  logic [PHI_W-1:0] phi_i,
    input  logic             iso_i,
    input  logic [ET_W-1:0]  thr_i,
    input  logic [ETA_W-1:0] eta_lo_i,
    input  logic [ETA_W-1:0] eta_hi_i,
    input  logic [PHI_W-1:0] phi_lo_i,
    input  logic [PHI_W-1:0] phi_hi_i,
    input  logic             iso_req_i,
    output logic             hit_o
);
    logic et_ok, eta_ok, phi_ok, iso_ok;

    always_comb begin
        et_ok  = (et_i >= thr_i);
        eta_ok = (eta_i >= eta_lo_i) && (eta_i <= eta_hi_i);
        if (phi_lo_i <= phi_hi_i) begin
            phi_ok = (phi_i >= phi_lo_i) && (phi_i <= phi_hi_i);
        end else begin
            // window crosses the wrap point
            phi_ok = (phi_i >= phi_lo_i) || (phi_i <= phi_hi_i);
        end
        iso_ok = iso_i || !iso_req_i;
        hit_o  = et_ok && eta_ok && phi_ok && iso_ok;
    end
endmodule

// File: rtl/pair_sep.sv
module pair_sep #(
    parameter int ETA_W    = 6,
    parameter int PHI_W    = 7,
    parameter int PHI_BINS = 72
) (
    input  logic [ETA_W-1:0] eta_a_i,
    input  logic [ETA_W-1:0] eta_b_i,
    input  logic [PHI_W-1:0] phi_a_i,
    input  logic [PHI_W-1:0] phi_b_i,
    input  logic [ETA_W-1:0] deta_max_i,
    input  logic [PHI_W-1:0] dphi_max_i,
    output logic             ok_o
);
    localparam logic [PHI_W-1:0] BINS = PHI_W'(PHI_BINS);

    logic [ETA_W-1:0] deta;
    logic [PHI_W-1:0] darc, dalt, dphi;

    always_comb begin
        deta = (eta_a_i >= eta_b_i) ? (eta_a_i - eta_b_i) : (eta_b_i - eta_a_i);
        darc = (phi_a_i >= phi_b_i) ? (phi_a_i - phi_b_i) : (phi_b_i - phi_a_i);
        dalt = BINS - darc;
        dphi = (darc <= dalt) ? darc : dalt;
        ok_o = (deta <= deta_max_i) && (dphi <= dphi_max_i);
    end
endmodule

// File: rtl/trig_pair_cond.sv
module trig_pair_cond
    import trig_pair_pkg::*;
#(
    parameter int N_OBJ    = DEF_N_OBJ,
    parameter int ET_W     = DEF_ET_W,
    parameter int ETA_W    = DEF_ETA_W,
    parameter int PHI_W    = DEF_PHI_W,
    parameter int PHI_BINS = DEF_PHI_BINS,
    parameter int MET_W    = DEF_MET_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_i,
    input  logic [N_OBJ*ET_W-1:0]  obj_et_i,
    input  logic [N_OBJ*ETA_W-1:0] obj_eta_i,
    input  logic [N_OBJ*PHI_W-1:0] obj_phi_i,
    input  logic [N_OBJ-1:0]       obj_iso_i,
    input  logic [MET_W-1:0]       met_i,
    input  logic [ET_W-1:0]        s1_et_thr_i,
    input  logic [ETA_W-1:0]       s1_eta_lo_i,
    input  logic [ETA_W-1:0]       s1_eta_hi_i,
    input  logic [PHI_W-1:0]       s1_phi_lo_i,
    input  logic [PHI_W-1:0]       s1_phi_hi_i,
    input  logic                   s1_iso_req_i,
    input  logic [ET_W-1:0]        s2_et_thr_i,
    input  logic [ETA_W-1:0]       s2_eta_lo_i,
    input  logic [ETA_W-1:0]       s2_eta_hi_i,
    input  logic [PHI_W-1:0]       s2_phi_lo_i,
    input  logic [PHI_W-1:0]       s2_phi_hi_i,
    input  logic                   s2_iso_req_i,
    input  logic                   corr_en_i,
    input  logic [ETA_W-1:0]       deta_max_i,
    input  logic [PHI_W-1:0]       dphi_max_i,
    input  logic [MET_W-1:0]       met_thr_i,
    output logic                   valid_o,
    output logic                   pair_o,
    output logic                   met_o
);
    localparam int N_PAIR = N_OBJ * N_OBJ;

    // per-set configuration gathered into arrays so the generate loop can index them
    logic [ET_W-1:0]  thr_c    [N_SETS];
    logic [ETA_W-1:0] eta_lo_c [N_SETS];
    logic [ETA_W-1:0] eta_hi_c [N_SETS];
    logic [PHI_W-1:0] phi_lo_c [N_SETS];
    logic [PHI_W-1:0] phi_hi_c [N_SETS];
    logic             iso_rq_c [N_SETS];

    assign thr_c[0]    = s1_et_thr_i;
    assign thr_c[1]    = s2_et_thr_i;
    assign eta_lo_c[0] = s1_eta_lo_i;
    assign eta_lo_c[1] = s2_eta_lo_i;
    assign eta_hi_c[0] = s1_eta_hi_i;
    assign eta_hi_c[1] = s2_eta_hi_i;
    assign phi_lo_c[0] = s1_phi_lo_i;
    assign phi_lo_c[1] = s2_phi_lo_i;
    assign phi_hi_c[0] = s1_phi_hi_i;
    assign phi_hi_c[1] = s2_phi_hi_i;
    assign iso_rq_c[0] = s1_iso_req_i;
    assign iso_rq_c[1] = s2_iso_req_i;

    logic [N_OBJ-1:0]  hit_w [N_SETS];
    logic [N_PAIR-1:0] sep_w;

    for (genvar s = 0; s < N_SETS; s++) begin : g_set
        for (genvar i = 0; i < N_OBJ; i++) begin : g_obj
            obj_match #(
                .ET_W (ET_W),
                .ETA_W(ETA_W),
                .PHI_W(PHI_W)
            ) u_match (
                .et_i     (obj_et_i[i*ET_W +: ET_W]),
                .eta_i    (obj_eta_i[i*ETA_W +: ETA_W]),
                .phi_i    (obj_phi_i[i*PHI_W +: PHI_W]),
                .iso_i    (obj_iso_i[i]),
                .thr_i    (thr_c[s]),
                .eta_lo_i (eta_lo_c[s]),
                .eta_hi_i (eta_hi_c[s]),
                .phi_lo_i (phi_lo_c[s]),
                .phi_hi_i (phi_hi_c[s]),
                .iso_req_i(iso_rq_c[s]),
                .hit_o    (hit_w[s][i])
            );
        end
    end

    for (genvar i = 0; i < N_OBJ; i++) begin : g_pa
        for (genvar j = 0; j < N_OBJ; j++) begin : g_pb
            if (i == j) begin : g_self
                assign sep_w[i*N_OBJ+j] = 1'b0;
            end else begin : g_other
                pair_sep #(
                    .ETA_W   (ETA_W),
                    .PHI_W   (PHI_W),
                    .PHI_BINS(PHI_BINS)
                ) u_sep (
                    .eta_a_i   (obj_eta_i[i*ETA_W +: ETA_W]),
                    .eta_b_i   (obj_eta_i[j*ETA_W +: ETA_W]),
                    .phi_a_i   (obj_phi_i[i*PHI_W +: PHI_W]),
                    .phi_b_i   (obj_phi_i[j*PHI_W +: PHI_W]),
                    .deta_max_i(deta_max_i),
                    .dphi_max_i(dphi_max_i),
                    .ok_o      (sep_w[i*N_OBJ+j])
                );
            end
        end
    end

    typedef struct packed {
        logic              v1;
        logic [N_OBJ-1:0]  h1;
        logic [N_OBJ-1:0]  h2;
        logic [N_PAIR-1:0] link;
        logic              met1;
        logic              v2;
        logic              pair2;
        logic              met2;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        logic any_pair;
        st_d = st_q;
        // stage 1: per-object matches and pair admissibility
        st_d.v1   = valid_i;
        st_d.h1   = valid_i ? hit_w[0] : '0;
        st_d.h2   = valid_i ? hit_w[1] : '0;
        st_d.met1 = valid_i && (met_i >= met_thr_i);
        for (int i = 0; i < N_OBJ; i++) begin
            for (int j = 0; j < N_OBJ; j++) begin
                st_d.link[i*N_OBJ+j] = (i != j) && (!corr_en_i || sep_w[i*N_OBJ+j]);
            end
        end
        // stage 2: reduce over ordered pairs
        any_pair = 1'b0;
        for (int i = 0; i < N_OBJ; i++) begin
            for (int j = 0; j < N_OBJ; j++) begin
                any_pair = any_pair | (st_q.h1[i] & st_q.h2[j] & st_q.link[i*N_OBJ+j]);
            end
        end
        st_d.v2    = st_q.v1;
        st_d.pair2 = st_q.v1 && any_pair;
        st_d.met2  = st_q.v1 && st_q.met1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.v2;
    assign pair_o  = st_q.pair2;
    assign met_o   = st_q.met2;
endmodule

// File: rtl/trig_pair_cond_chk.sv
module trig_pair_cond_chk #(
    parameter int MET_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [MET_W-1:0] met_i,
    input logic [MET_W-1:0] met_thr_i,
    input logic             valid_o,
    input logic             pair_o,
    input logic             met_o
);
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == $past(valid_i, 2));

    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!pair_o && !met_o));

    a_r9_met_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (met_o == ($past(met_i, 2) >= $past(met_thr_i, 2))));

    a_r10_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!valid_o && !pair_o && !met_o));
endmodule

bind trig_pair_cond trig_pair_cond_chk #(.MET_W(MET_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .met_i    (met_i),
    .met_thr_i(met_thr_i),
    .valid_o  (valid_o),
    .pair_o   (pair_o),
    .met_o    (met_o)
);

// File: tb/test_trig_pair_cond.sv
module test_trig_pair_cond;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [39:0] obj_et_i = '0;
    logic [23:0] obj_eta_i = '0;
    logic [27:0] obj_phi_i = '0;
    logic [3:0]  obj_iso_i = '0;
    logic [11:0] met_i = '0;
    logic        s1_iso_req = 1'b0;
    logic        corr_en = 1'b0;
    logic        valid_o, pair_o, met_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_pair_cond i_trig_pair_cond (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
        .obj_et_i(obj_et_i), .obj_eta_i(obj_eta_i), .obj_phi_i(obj_phi_i),
        .obj_iso_i(obj_iso_i), .met_i(met_i),
        .s1_et_thr_i(10'd20), .s1_eta_lo_i(6'd10), .s1_eta_hi_i(6'd50),
        .s1_phi_lo_i(7'd0), .s1_phi_hi_i(7'd71), .s1_iso_req_i(s1_iso_req),
        .s2_et_thr_i(10'd40), .s2_eta_lo_i(6'd20), .s2_eta_hi_i(6'd40),
        .s2_phi_lo_i(7'd60), .s2_phi_hi_i(7'd10), .s2_iso_req_i(1'b0),
        .corr_en_i(corr_en), .deta_max_i(6'd5), .dphi_max_i(7'd6),
        .met_thr_i(12'd100),
        .valid_o(valid_o), .pair_o(pair_o), .met_o(met_o)
    );

    typedef struct packed {
        logic [39:0] et;
        logic [23:0] eta;
        logic [27:0] phi;
        logic        corr;
        logic [11:0] met;
        logic        exp_pair;
        logic        exp_met;
    } vec_t;

    // set 1: et>=20, eta 10..50, any phi; set 2: et>=40, eta 20..40, phi 60..71 or 0..10
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // v0 empty crossing, met 99 under threshold (R9)
        '{40'd0, 24'd0, 28'd0, 1'b0, 12'd99, 1'b0, 1'b0},
        // v1 one object meets both sets alone (R6), met on threshold (R9)
        '{{10'd0,10'd0,10'd0,10'd50}, {6'd0,6'd0,6'd0,6'd30}, {7'd0,7'd0,7'd0,7'd5},
          1'b0, 12'd100, 1'b0, 1'b1},
        // v2 distinct pair, no correlation (R6)
        '{{10'd0,10'd0,10'd25,10'd50}, {6'd0,6'd0,6'd12,6'd30}, {7'd0,7'd0,7'd40,7'd5},
          1'b0, 12'd0, 1'b1, 1'b0},
        // v3 same pair, eta separation 18 too large (R7)
        '{{10'd0,10'd0,10'd25,10'd50}, {6'd0,6'd0,6'd12,6'd30}, {7'd0,7'd0,7'd40,7'd5},
          1'b1, 12'd0, 1'b0, 1'b0},
        // v4 et equal to thresholds (R2), phi 70 vs 2 wraps to 4 (R8)
        '{{10'd0,10'd0,10'd20,10'd40}, {6'd0,6'd0,6'd33,6'd30}, {7'd0,7'd0,7'd2,7'd70},
          1'b1, 12'd0, 1'b1, 1'b0},
        // v5 set 2 energy one below threshold (R2)
        '{{10'd0,10'd0,10'd20,10'd39}, {6'd0,6'd0,6'd33,6'd30}, {7'd0,7'd0,7'd2,7'd70},
          1'b1, 12'd0, 1'b0, 1'b0},
        // v6 phi 35 outside wrapped set 2 window (R4)
        '{{10'd0,10'd0,10'd30,10'd60}, {6'd0,6'd0,6'd30,6'd30}, {7'd0,7'd0,7'd35,7'd35},
          1'b0, 12'd0, 1'b0, 1'b0},
        // v7 eta on both window edges, phi on wrap lower bound (R3, R4)
        '{{10'd0,10'd21,10'd0,10'd60}, {6'd0,6'd50,6'd0,6'd20}, {7'd0,7'd0,7'd0,7'd60},
          1'b0, 12'd4095, 1'b1, 1'b1},
        // v8 eta one step outside each window (R3)
        '{{10'd0,10'd60,10'd0,10'd60}, {6'd0,6'd51,6'd0,6'd19}, {7'd0,7'd0,7'd0,7'd0},
          1'b0, 12'd0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // present one crossing, wait two edges, sample at the falling edge
    task automatic run(input logic [39:0] et, input logic [23:0] eta,
                       input logic [27:0] phi, input logic [3:0] iso,
                       input logic corr, input logic [11:0] met);
        @(negedge clk);
        obj_et_i = et; obj_eta_i = eta; obj_phi_i = phi; obj_iso_i = iso;
        corr_en = corr; met_i = met; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 valid", valid_o, 1'b0);
        check("R10 pair", pair_o, 1'b0);
        check("R10 met", met_o, 1'b0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            run(VECS[k].et, VECS[k].eta, VECS[k].phi, 4'b0000, VECS[k].corr, VECS[k].met);
            check($sformatf("R6 pair vec%0d", k), pair_o, VECS[k].exp_pair);
            check($sformatf("R9 met vec%0d", k), met_o, VECS[k].exp_met);
            check($sformatf("R1 valid vec%0d", k), valid_o, 1'b1);
        end

        // R1 latency: one pulse, observe after each edge
        @(negedge clk);
        met_i = 12'd200; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check("R1 not yet after one edge", valid_o, 1'b0);
        @(negedge clk);
        check("R1 valid after two edges", valid_o, 1'b1);
        @(negedge clk);
        check("R1 drops after pulse", valid_o, 1'b0);
        check("R1 met quiet when not valid", met_o, 1'b0);

        // R5 isolation required on set 1
        s1_iso_req = 1'b1;
        run(VECS[2].et, VECS[2].eta, VECS[2].phi, 4'b0000, 1'b0, 12'd0);
        check("R5 non-isolated masked", pair_o, 1'b0);
        run(VECS[2].et, VECS[2].eta, VECS[2].phi, 4'b0010, 1'b0, 12'd0);
        check("R5 isolated accepted", pair_o, 1'b1);
        s1_iso_req = 1'b0;

        // R8 wrapped phi distance on the limit and one past it
        run({10'd0,10'd0,10'd20,10'd40}, {6'd0,6'd0,6'd30,6'd30},
            {7'd0,7'd0,7'd0,7'd66}, 4'b0000, 1'b1, 12'd0);
        check("R8 dphi 6 passes", pair_o, 1'b1);
        run({10'd0,10'd0,10'd20,10'd40}, {6'd0,6'd0,6'd30,6'd30},
            {7'd0,7'd0,7'd0,7'd65}, 4'b0000, 1'b1, 12'd0);
        check("R8 dphi 7 fails", pair_o, 1'b0);
        // R7 same crossing with correlation off
        run({10'd0,10'd0,10'd20,10'd40}, {6'd0,6'd0,6'd30,6'd30},
            {7'd0,7'd0,7'd0,7'd65}, 4'b0000, 1'b0, 12'd0);
        check("R7 limits ignored when disabled", pair_o, 1'b1);

        // R10 reset in flight
        @(negedge clk);
        obj_et_i = VECS[2].et; obj_eta_i = VECS[2].eta; obj_phi_i = VECS[2].phi;
        met_i = 12'd500; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 valid cleared", valid_o, 1'b0);
        check("R10 pair cleared", pair_o, 1'b0);
        check("R10 met cleared", met_o, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 stays clear after release", valid_o, 1'b0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule